// File: doc/BRIEF.md
# I2S Audio Transmit Channel

This block drains 32-bit audio words from an eight-entry transmit queue and shifts them out as a standard I2S stream: a bit clock, a word-select line that is low for the left slot and high for the right slot, and one serial data line. The data starts with the MSB, one bit clock after each word-select change. Data changes only on the falling edge of the bit clock.

As bus master, the block divides the system clock to make the bit clock. It toggles word select after a programmable number of bit clocks, and that number is independent of the sample width. As slave, it synchronises an external bit clock and word select and shifts on their falling edges. Control inputs select the sample width, mono or stereo, the half-frame length, the divider and the queue threshold, and they provide mute, stop and clear. The block raises an interrupt and a DMA request while the queue is at or below the threshold. A sticky flag records any slot that found the queue empty.

Top module: `i2s_tx`

## Requirements
- R1: In master mode, `sck_out` has a period of 2*(`cfg_div`+1) system clocks. Each word-select half-period lasts `cfg_half`+1 bit clocks. In slave mode, `sck_out` stays low.
- R2: Every word-select change and every data change happens together with a falling edge of the bit clock. The MSB of a slot appears one bit clock after the word-select change. Word select low (0) marks the left slot, and high (1) marks the right slot.
- R3: `cfg_wsize` selects the sample width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 gives 32 bits. The sample is taken from the low bits of the queued word. Bit positions past the sample width within a slot are sent as 0. If the slot is shorter than the sample, the sample is cut off after its first bits.
- R4: In stereo (`cfg_mono`=0), each slot consumes one queued word, starting with the left slot. In mono, each left slot consumes one word, and the right slot that follows repeats it.
- R5: In slave mode, the channel follows the external `sck_in`/`ws_in` after a two-stage synchroniser. It shifts one bit per falling edge of `sck_in` and starts a slot whenever the sampled word select changes.
- R6: The queue holds 8 words. `wr_full` is high when 8 words are stored, and a write while full is dropped.
- R7: `irq` and `dma_req` are both high exactly when the queue fill level is less than or equal to `cfg_level`.
- R8: While `cfg_mute` is high, slots carry all-zero data. Framing and queue consumption continue as normal.
- R9: While `cfg_stop` is high, the bit clock and word select freeze and no word is consumed. Clearing `cfg_stop` resumes the stream where it stopped.
- R10: `cfg_reset` (and `rst`) empties the queue, clears `underrun`, and puts the serializer in idle: `sck_out`=0, `ws_out`=1, `sd_out`=0.
- R11: A slot that needs a word while the queue is empty sends zeros and sets the sticky `underrun` flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = generate bit clock and word select, 0 = follow external ones |
| cfg_mono | input | 1 | 1 = one word per frame, sent in both slots |
| cfg_wsize | input | 2 | Sample width code (0:8, 1:16, 2/3:32) |
| cfg_half | input | 5 | Bit clocks per word-select half-period, minus one |
| cfg_div | input | 8 | System clocks per bit-clock half-period, minus one |
| cfg_level | input | 4 | Queue threshold for irq and dma_req |
| cfg_mute | input | 1 | Send zero data while framing continues |
| cfg_stop | input | 1 | Freeze the transfer |
| cfg_reset | input | 1 | Empty the queue and put the serializer in idle |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 32 | Word to queue (sample in low bits) |
| wr_full | output | 1 | Queue holds 8 words |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Word select |
| sd_out | output | 1 | Serial data |
| irq | output | 1 | Fill level at or below threshold |
| dma_req | output | 1 | Fill level at or below threshold |
| underrun | output | 1 | Sticky empty-queue flag |

## Verification
The embedded properties check the following on every cycle:
- In master mode, word select moves only on a falling bit-clock edge.
- The bit clock and word select stay frozen while stopped.
- A clear leaves the outputs idle.
- The queue never holds more than its depth, and it ignores writes while full.
- The underrun flag stays set until cleared.

Some behaviour only the bench scenarios can show. These are the bit-exact content of each slot across sample widths, slot lengths shorter than the sample, mono repetition, muting, slave-mode following, and the sequence in which words are consumed. The bench shows these by rebuilding each slot from the pins and comparing it with a queue model.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SAMPLE_W = 32;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        SZ_8   = 2'd0,
        SZ_16  = 2'd1,
        SZ_32  = 2'd2,
        SZ_32X = 2'd3
    } wsize_e;

    // One bit-clock falling event and the word-select value that goes with it
    typedef struct packed {
        logic tick;
        logic ws;
    } bitev_t;

    // Decision taken when a slot begins
    typedef struct packed {
        logic    start;
        logic    left;
        logic    need;
        sample_t word;
    } slot_t;

    // Move the sample to the top of the shift word, zero below it
    function automatic sample_t left_align(sample_t w, wsize_e sz);
        sample_t r;
        case (sz)
            SZ_8:    r = {w[7:0],  {(SAMPLE_W-8){1'b0}}};
            SZ_16:   r = {w[15:0], {(SAMPLE_W-16){1'b0}}};
            default: r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo
    import i2s_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr,
    input  sample_t          wdata,
    input  logic             rd,
    output sample_t          rdata,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    sample_t          mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [LVL_W-1:0] cnt;
    logic             do_wr, do_rd;

    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == LVL_W'(DEPTH));
        do_wr = wr && !full && !clr;
        do_rd = rd && !empty && !clr;
        rdata = mem[rp];
        level = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= LVL_W'(DEPTH)); // R6

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        full && wr && !rd && !clr |=> full); // R6

endmodule

// File: rtl/i2s_tx_bitclk.sv
module i2s_tx_bitclk
    import i2s_tx_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              master,
    input  logic              stop,
    input  logic [DIV_W-1:0]  div,
    input  logic [HALF_W-1:0] half_m1,
    input  logic              sck_in,
    input  logic              ws_in,
    input  logic              ws_cur,
    output bitev_t            ev,
    output logic              sck_o
);

    logic [DIV_W-1:0]  divc;
    logic              sck_q;
    logic [HALF_W-1:0] bitc;
    logic [2:0]        sck_sy;
    logic [1:0]        ws_sy;
    logic              run_m, edge_m, wrap, fall_s;

    always_comb begin
        run_m  = master && !stop;
        edge_m = run_m && (divc >= div);
        wrap   = (bitc >= half_m1);
        fall_s = sck_sy[2] && !sck_sy[1];
        if (master) begin
            ev.tick = edge_m && sck_q;
            ev.ws   = wrap ? !ws_cur : ws_cur;
        end else begin
            ev.tick = !stop && fall_s;
            ev.ws   = ws_sy[1];
        end
        sck_o = master && sck_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            divc   <= '0;
            sck_q  <= 1'b0;
            bitc   <= '1;
            sck_sy <= '0;
            ws_sy  <= '0;
        end else begin
            sck_sy <= {sck_sy[1:0], sck_in};
            ws_sy  <= {ws_sy[0], ws_in};
            if (run_m) begin
                if (edge_m) begin
                    divc  <= '0;
                    sck_q <= !sck_q;
                    if (sck_q) bitc <= wrap ? '0 : bitc + 1'b1;
                end else begin
                    divc <= divc + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser
    import i2s_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  bitev_t  ev,
    input  logic    mono,
    input  logic    mute,
    input  wsize_e  wsize,
    input  logic    fifo_empty,
    input  sample_t fifo_data,
    output logic    pop,
    output logic    ws_q,
    output logic    sd,
    output logic    underrun
);

    sample_t sh, hold;
    slot_t   slot;

    always_comb begin
        slot.start = ev.tick && (ev.ws != ws_q);
        slot.left  = !ev.ws;
        slot.need  = slot.start && (!mono || slot.left);
        if (mono && !slot.left)
            slot.word = hold;
        else if (fifo_empty)
            slot.word = '0;
        else
            slot.word = left_align(fifo_data, wsize);
        pop = slot.need && !fifo_empty;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ws_q     <= 1'b1;
            sd       <= 1'b0;
            sh       <= '0;
            hold     <= '0;
            underrun <= 1'b0;
        end else if (ev.tick) begin
            sd   <= sh[SAMPLE_W-1];
            ws_q <= ev.ws;
            if (slot.start) begin
                sh <= mute ? '0 : slot.word;
                if (slot.left) hold <= slot.word;
                if (slot.need && fifo_empty) underrun <= 1'b1;
            end else begin
                sh <= {sh[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(underrun) && !$past(clr) |-> underrun); // R11

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
    import i2s_tx_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int DIV_W  = 8,
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int HALF_W = $clog2(SAMPLE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_mono,
    input  logic [1:0]        cfg_wsize,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic              cfg_mute,
    input  logic              cfg_stop,
    input  logic              cfg_reset,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic              wr_full,
    input  logic              sck_in,
    input  logic              ws_in,
    output logic              sck_out,
    output logic              ws_out,
    output logic              sd_out,
    output logic              irq,
    output logic              dma_req,
    output logic              underrun
);

    sample_t          q_data;
    logic             q_empty, q_pop;
    logic [LVL_W-1:0] q_level;
    bitev_t           ev;
    logic             ws_q;

    i2s_tx_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_reset),
        .wr    (wr_en),
        .wdata (wr_data),
        .rd    (q_pop),
        .rdata (q_data),
        .empty (q_empty),
        .full  (wr_full),
        .level (q_level)
    );

    i2s_tx_bitclk #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_reset),
        .master  (cfg_master),
        .stop    (cfg_stop),
        .div     (cfg_div),
        .half_m1 (cfg_half),
        .sck_in  (sck_in),
        .ws_in   (ws_in),
        .ws_cur  (ws_q),
        .ev      (ev),
        .sck_o   (sck_out)
    );

    i2s_tx_ser u_ser (
        .clk        (clk),
        .rst        (rst),
        .clr        (cfg_reset),
        .ev         (ev),
        .mono       (cfg_mono),
        .mute       (cfg_mute),
        .wsize      (wsize_e'(cfg_wsize)),
        .fifo_empty (q_empty),
        .fifo_data  (q_data),
        .pop        (q_pop),
        .ws_q       (ws_q),
        .sd         (sd_out),
        .underrun   (underrun)
    );

    always_comb begin
        ws_out  = ws_q;
        irq     = (q_level <= cfg_level);
        dma_req = (q_level <= cfg_level);
    end

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        cfg_master && $past(cfg_master) && !$past(cfg_reset) && !$stable(ws_out)
        |-> $fell(sck_out)); // R2

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        cfg_master && $past(cfg_master) && $past(cfg_stop) && !$past(cfg_reset)
        |-> $stable(sck_out) && $stable(ws_out)); // R9

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_reset |=> !sck_out && ws_out && !sd_out && !underrun && irq); // R10

endmodule

// File: tb/sim_i2s_tx.sv
module sim_i2s_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b1, cfg_mono = 1'b0, cfg_mute = 1'b0;
    logic        cfg_stop = 1'b1, cfg_reset = 1'b0;
    logic [1:0]  cfg_wsize = 2'd1;
    logic [4:0]  cfg_half = 5'd15;
    logic [7:0]  cfg_div = 8'd1;
    logic [3:0]  cfg_level = 4'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sck_in = 1'b0, ws_in = 1'b1;
    logic        wr_full, sck_out, ws_out, sd_out, irq, dma_req, underrun;

    always #5 clk = ~clk;

    i2s_tx u0 (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_mono(cfg_mono),
        .cfg_wsize(cfg_wsize), .cfg_half(cfg_half), .cfg_div(cfg_div),
        .cfg_level(cfg_level), .cfg_mute(cfg_mute), .cfg_stop(cfg_stop),
        .cfg_reset(cfg_reset), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out), .ws_out(ws_out),
        .sd_out(sd_out), .irq(irq), .dma_req(dma_req), .underrun(underrun)
    );

    int          checks = 0, fails = 0;
    logic [31:0] q[$];
    logic [31:0] hold_m = '0;
    bit          exp_und, mon_en = 0, started, prev_sck, prev_ws, done;
    int          nb, slots, target, last_rise = -1, cyc = 0;
    logic [31:0] acc;

    function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    function automatic logic [31:0] al(logic [31:0] w, logic [1:0] s);
        case (s)
            2'd0:    return w << 24;
            2'd1:    return w << 16;
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] slot_bits(logic [31:0] w, int n);
        return (n >= 32) ? w : (w >> (32 - n));
    endfunction

    function automatic void finish_slot(bit w);
        logic [31:0] word;
        bit          need, und_e;
        string       tag;
        need = !cfg_mono || (w == 1'b0);
        if (need) begin
            if (q.size() > 0) word = al(q.pop_front(), cfg_wsize);
            else begin word = '0; exp_und = 1; end
            if (cfg_mono) hold_m = word;
        end else begin
            word = hold_m;
        end
        if (cfg_mute) word = '0;
        chk(nb == int'(cfg_half) + 1, "R1 slot length", nb, cfg_half + 1);
        tag = $sformatf("R2 R3 R4 slot data ws=%0d%s%s", w, cfg_mute ? " R8" : "",
                        cfg_master ? "" : " R5");
        chk(acc == slot_bits(word, nb), tag, acc, slot_bits(word, nb));
        slots++;
        if (slots == target) begin
            und_e = exp_und || ((!cfg_mono || w == 1'b1) && q.size() == 0);
            chk(underrun == und_e, "R11 underrun flag", underrun, und_e);
            done = 1;
        end
    endfunction

    always @(negedge clk) begin : monitor
        logic bs, bw;
        cyc++;
        if (mon_en && !done) begin
            bs = cfg_master ? sck_out : sck_in;
            bw = cfg_master ? ws_out : ws_in;
            if (bs && !prev_sck) begin
                if (cfg_master && !cfg_stop && last_rise >= 0)
                    chk(cyc - last_rise == 2 * (cfg_div + 1), "R1 bit clock period",
                        cyc - last_rise, 2 * (cfg_div + 1));
                last_rise = cyc;
                acc = {acc[30:0], sd_out};
                nb++;
                if (bw != prev_ws) begin
                    if (started) finish_slot(prev_ws);
                    started = 1;
                    acc = '0;
                    nb = 0;
                end
                prev_ws = bw;
            end
            prev_sck = bs;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(logic [31:0] d);
        step();
        wr_en = 1'b1;
        wr_data = d;
        if (q.size() < 8) q.push_back(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic drive_slave(logic [4:0] h);
        int bc = int'(h);
        while (!done) begin
            repeat (6) step();
            sck_in = 1'b1;
            repeat (6) step();
            sck_in = 1'b0;
            if (bc == int'(h)) begin bc = 0; ws_in = ~ws_in; end
            else bc++;
        end
    endtask

    task automatic run(bit m, bit mono, logic [1:0] wsz, logic [4:0] h, logic [7:0] dv,
                       bit mute, int nw, int ns, bit extra, bit stop_mid);
        logic s0, w0;
        step();
        mon_en = 0;
        cfg_reset = 1'b1;
        cfg_stop = 1'b1;
        step();
        cfg_master = m; cfg_mono = mono; cfg_wsize = wsz; cfg_half = h;
        cfg_div = dv; cfg_mute = mute; cfg_level = 4'd0;
        sck_in = 1'b0; ws_in = 1'b1;
        q.delete();
        step();
        cfg_reset = 1'b0;
        for (int i = 0; i < nw; i++) push($urandom);
        if (nw == 8) begin
            @(negedge clk);
            chk(wr_full == 1'b1, "R6 full flag at 8 words", wr_full, 1);
        end
        if (extra) push($urandom);
        started = 0; prev_sck = 0; prev_ws = 1; last_rise = -1; slots = 0;
        target = ns; done = 0; exp_und = 0; acc = '0; nb = 0; hold_m = '0;
        step();
        mon_en = 1;
        cfg_stop = 1'b0;
        fork
            begin
                if (!m) drive_slave(h);
            end
            begin
                if (stop_mid) begin
                    repeat (150) step();
                    cfg_stop = 1'b1;
                    @(negedge clk);
                    s0 = sck_out; w0 = ws_out;
                    repeat (100) @(negedge clk);
                    chk(sck_out == s0 && ws_out == w0, "R9 frozen during stop",
                        {sck_out, ws_out}, {s0, w0});
                    step();
                    last_rise = -1;
                    cfg_stop = 1'b0;
                end
                wait (done);
            end
        join
    endtask

    task automatic thresh_test();
        bit e;
        step();
        mon_en = 0;
        cfg_reset = 1'b1; cfg_stop = 1'b1; cfg_master = 1'b1;
        step();
        cfg_reset = 1'b0; cfg_level = 4'd3;
        q.delete();
        for (int i = 0; i <= 8; i++) begin
            @(negedge clk);
            e = (i <= 3);
            chk(irq == e && dma_req == e, $sformatf("R7 level %0d", i), {irq, dma_req}, {e, e});
            if (i < 8) push(i);
        end
        chk(wr_full == 1'b1, "R6 full", wr_full, 1);
        push(32'hDEAD);
        @(negedge clk);
        chk(wr_full == 1'b1 && irq == 1'b0, "R6 write when full dropped", {wr_full, irq}, 2'b10);
    endtask

    task automatic reset_test();
        step();
        cfg_stop = 1'b1; cfg_level = 4'd0;
        push(32'h1); push(32'h2); push(32'h3);
        @(negedge clk);
        chk(irq == 1'b0 && dma_req == 1'b0, "R7 above threshold", {irq, dma_req}, 0);
        step();
        cfg_reset = 1'b1;
        step();
        @(negedge clk);
        chk(sck_out == 0 && ws_out == 1 && sd_out == 0, "R10 idle outputs",
            {sck_out, ws_out, sd_out}, 3'b010);
        chk(underrun == 1'b0, "R10 underrun cleared", underrun, 0);
        chk(irq == 1'b1 && wr_full == 1'b0, "R10 queue emptied", {irq, wr_full}, 2'b10);
        step();
        cfg_reset = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) step();
        rst = 1'b0;
        @(negedge clk);
        chk(sck_out == 0 && ws_out == 1 && sd_out == 0, "R10 reset outputs",
            {sck_out, ws_out, sd_out}, 3'b010);
        chk(underrun == 0 && irq == 1 && dma_req == 1 && wr_full == 0, "R10 reset flags",
            {underrun, irq, dma_req, wr_full}, 4'b0110);

        // directed corner cases
        run(1, 0, 2'd1, 5'd15, 8'd1, 0, 6, 6, 0, 0);   // stereo 16-bit
        run(1, 1, 2'd0, 5'd15, 8'd0, 0, 4, 8, 0, 0);   // mono 8-bit, padding
        run(1, 0, 2'd2, 5'd31, 8'd0, 0, 8, 9, 1, 0);   // full queue, dropped write, underrun
        reset_test();
        run(1, 0, 2'd2, 5'd11, 8'd1, 0, 4, 4, 0, 0);   // slot shorter than sample
        run(1, 0, 2'd1, 5'd15, 8'd0, 1, 4, 4, 0, 0);   // mute
        run(0, 0, 2'd1, 5'd15, 8'd0, 0, 5, 5, 0, 0);   // slave
        run(0, 1, 2'd0, 5'd9,  8'd0, 0, 3, 6, 0, 0);   // slave mono
        run(1, 0, 2'd1, 5'd15, 8'd2, 0, 8, 8, 0, 1);   // stop mid-stream
        thresh_test();

        // constrained random
        for (int k = 0; k < 8; k++) begin
            int nw;
            nw = 1 + int'($urandom % 8);
            run(1, 1'($urandom % 2), 2'($urandom % 4), 5'(7 + $urandom % 25),
                8'($urandom % 4), 1'($urandom % 4 == 0), nw, nw + 1, 0, 0);
        end

        summary();
        $finish;
    end

endmodule